// File: doc/BRIEF.md
# Bridge Short-Circuit Fault Sequencer

This block sits between the short-detect comparators of an H-bridge and the gate drive. It watches one short flag per power switch plus a thermal-shutdown flag, and from them it decides whether the bridge may conduct. It also drives a warning line that external logic can read. A short must be present without a break for a qualification interval before anything happens, so switching noise that lasts a few cycles is filtered out.

A mode pin selects how the block answers a confirmed short. In latching mode the bridge is switched off for a hold interval and then given one more chance. If the short is confirmed again, the bridge is locked off, and only a low level on the run-enable pin (or a reset) releases it. In auto-retry mode the bridge is switched off for a pause interval and then switched back on. This repeats for as long as the short keeps being confirmed. Thermal shutdown switches the bridge off while the flag is set and gives control back when the flag drops. All intervals are counted in clock cycles and set by parameters.

Top module: `short_guard_seq`

## Requirements
- R1: After reset, with no fault flag set, `bridge_en` is 1 and `warn_drv` is 0.
- R2: `short_hit` is the OR of all per-switch bits. When it is 1 on QUAL_CYC consecutive rising edges, the short is confirmed and `bridge_en` falls right after the last of those edges. A single edge with it at 0 restarts the count, so a pulse of QUAL_CYC-1 cycles has no effect.
- R3: A short confirmed while `retry_mode` is 0 turns the bridge off for exactly HOLD_CYC cycles. The bridge is then turned on again for a recheck.
- R4: During the recheck, if the short is 1 on QUAL_CYC consecutive edges starting from the recheck, the bridge locks off. It stays off whatever `short_hit` does afterwards, as long as `run_en` stays 1.
- R5: If `short_hit` is 0 on the first edge of the recheck, normal operation resumes. A later short goes through the full sequence again, including the hold interval.
- R6: While `run_en` is 0, the lock is cleared, all timers are held at zero and `short_hit` is ignored.
- R7: A short confirmed while `retry_mode` is 1 turns the bridge off for exactly AUTO_OFF_CYC cycles and then back on. This repeats for each new confirmation, and the block never locks.
- R8: `therm_hot` is sampled on each edge. While the sampled value is 1, `bridge_en` is 0. The bridge comes back on after the first edge that samples 0, unless a short-protection phase is holding it off.
- R9: `warn_drv` (1 = pull the open-drain warning line low) is 1 exactly when the bridge is held off by short protection or by thermal shutdown.
- R10: The response mode is taken from `retry_mode` at the moment of confirmation. Changing the pin during an off phase does not change that phase's length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| run_en | input | 1 | Power-save control; 0 holds the sequencer idle and clears the lock |
| retry_mode | input | 1 | 0 = latching response, 1 = auto-retry response |
| short_hit | input | NUM_SW | Per-switch short-detect flags |
| therm_hot | input | 1 | Thermal-shutdown flag |
| bridge_en | output | 1 | 1 = bridge may conduct |
| warn_drv | output | 1 | 1 = warning line pulled low |

## Verification
Every input passes through exactly one register stage before it reaches the outputs, because both outputs are decoded from registered state. A change driven on a falling edge therefore shows up after the next rising edge. The one exception is the qualification interval, which needs QUAL_CYC edges before it reacts. After the external reset is released, the internal reset takes two more rising edges to release. The bench keeps a behavioural model that follows these same latencies. It updates the model on every rising edge and compares both outputs on every falling edge. It also takes explicit level checks at points that lie well inside the off and on phases, and one check placed exactly on the cycle where the hold and pause lengths differ.

// File: rtl/sgs_pkg.sv
package sgs_pkg;
  typedef enum logic [2:0] {
    ST_RUN     = 3'd0,
    ST_COOL    = 3'd1,
    ST_RECHECK = 3'd2,
    ST_LOCK    = 3'd3,
    ST_PAUSE   = 3'd4
  } seq_st_e;
endpackage

// File: rtl/sgs_qualifier.sv
module sgs_qualifier #(
  parameter int unsigned QUAL_CYC = 500
) (
  input  logic clk,
  input  logic rst_n,
  input  logic arm,
  input  logic hit,
  output logic trip
);
  localparam int unsigned QW = (QUAL_CYC < 2) ? 1 : $clog2(QUAL_CYC);

  logic [QW-1:0] streak_q, streak_d;

  always_comb begin
    trip     = arm && hit && (streak_q == QW'(QUAL_CYC - 1));
    streak_d = streak_q;
    if (!arm || !hit || trip) begin
      streak_d = '0;
    end else begin
      streak_d = streak_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      streak_q <= '0;
    end else begin
      streak_q <= streak_d;
    end
  end
endmodule

// File: rtl/sgs_interval.sv
module sgs_interval #(
  parameter int unsigned LEN_A = 2500,
  parameter int unsigned LEN_B = 250000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic sel_b,
  output logic done
);
  localparam int unsigned LEN_MAX = (LEN_A > LEN_B) ? LEN_A : LEN_B;
  localparam int unsigned TW      = (LEN_MAX < 2) ? 1 : $clog2(LEN_MAX);

  logic [TW-1:0] tick_q, tick_d;
  logic [TW-1:0] last_tick;

  always_comb begin
    last_tick = sel_b ? TW'(LEN_B - 1) : TW'(LEN_A - 1);
    done      = run && (tick_q == last_tick);
    if (!run || done) begin
      tick_d = '0;
    end else begin
      tick_d = tick_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tick_q <= '0;
    end else begin
      tick_q <= tick_d;
    end
  end
endmodule

// File: rtl/sgs_sequencer.sv
module sgs_sequencer
  import sgs_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    run_en,
  input  logic    retry_mode,
  input  logic    hit,
  input  logic    trip,
  input  logic    done,
  output seq_st_e st
);
  seq_st_e st_d;

  always_comb begin
    st_d = st;
    if (!run_en) begin
      st_d = ST_RUN;
    end else begin
      case (st)
        ST_RUN: begin
          if (trip) st_d = retry_mode ? ST_PAUSE : ST_COOL;
        end
        ST_COOL: begin
          if (done) st_d = ST_RECHECK;
        end
        ST_RECHECK: begin
          if (!hit)      st_d = ST_RUN;
          else if (trip) st_d = ST_LOCK;
        end
        ST_LOCK:  st_d = ST_LOCK;
        ST_PAUSE: begin
          if (done) st_d = ST_RUN;
        end
        default: st_d = ST_RUN;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= ST_RUN;
    end else begin
      st <= st_d;
    end
  end
endmodule

// File: rtl/short_guard_seq.sv
module short_guard_seq
  import sgs_pkg::*;
#(
  parameter int unsigned NUM_SW       = 4,
  parameter int unsigned QUAL_CYC     = 500,
  parameter int unsigned HOLD_CYC     = 2500,
  parameter int unsigned AUTO_OFF_CYC = 250000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run_en,
  input  logic              retry_mode,
  input  logic [NUM_SW-1:0] short_hit,
  input  logic              therm_hot,
  output logic              bridge_en,
  output logic              warn_drv
);
  logic [1:0] rst_sync_q;
  logic       rst_core_n;
  logic       therm_q;
  logic       hit_any;
  logic       qual_arm;
  logic       trip;
  logic       tmr_run;
  logic       tmr_done;
  logic       conducting;
  seq_st_e    st;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync_q <= 2'b00;
    end else begin
      rst_sync_q <= {rst_sync_q[0], 1'b1};
    end
  end
  assign rst_core_n = rst_sync_q[1];

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) begin
      therm_q <= 1'b0;
    end else begin
      therm_q <= therm_hot;
    end
  end

  assign hit_any    = |short_hit;
  assign conducting = (st == ST_RUN) || (st == ST_RECHECK);
  assign qual_arm   = run_en && conducting;
  assign tmr_run    = run_en && ((st == ST_COOL) || (st == ST_PAUSE));

  sgs_qualifier #(.QUAL_CYC(QUAL_CYC)) u_qual (
    .clk   (clk),
    .rst_n (rst_core_n),
    .arm   (qual_arm),
    .hit   (hit_any),
    .trip  (trip)
  );

  sgs_interval #(.LEN_A(HOLD_CYC), .LEN_B(AUTO_OFF_CYC)) u_tmr (
    .clk   (clk),
    .rst_n (rst_core_n),
    .run   (tmr_run),
    .sel_b (st == ST_PAUSE),
    .done  (tmr_done)
  );

  sgs_sequencer u_seq (
    .clk        (clk),
    .rst_n      (rst_core_n),
    .run_en     (run_en),
    .retry_mode (retry_mode),
    .hit        (hit_any),
    .trip       (trip),
    .done       (tmr_done),
    .st         (st)
  );

  assign bridge_en = conducting && !therm_q;
  assign warn_drv  = therm_q || !conducting;
endmodule

// File: rtl/sgs_checker.sv
module sgs_checker
  import sgs_pkg::*;
(
  input logic    clk,
  input logic    rst_n,
  input logic    run_en,
  input logic    retry_mode,
  input logic    hit_any,
  input logic    therm_q,
  input seq_st_e st,
  input logic    bridge_en,
  input logic    warn_drv
);
  AST_LOCK_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_LOCK && run_en) |=> (st == ST_LOCK)); // R4
  AST_LOCK_FROM_RECHECK: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_LOCK && $past(st) != ST_LOCK) |-> ($past(st) == ST_RECHECK)); // R4
  AST_RUNEN_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    !run_en |=> (st == ST_RUN)); // R6
  AST_THERM_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    therm_q |-> (!bridge_en && warn_drv)); // R8
  AST_COOL_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_COOL && $past(st) == ST_RUN) |-> (!$past(retry_mode) && $past(hit_any))); // R3
  AST_PAUSE_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_PAUSE && $past(st) == ST_RUN) |-> $past(retry_mode)); // R7
  AST_PROT_WARN: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_COOL || st == ST_LOCK || st == ST_PAUSE) |-> (warn_drv && !bridge_en)); // R9
  AST_RECHECK_ON: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_RECHECK && !therm_q) |-> bridge_en); // R3
endmodule

bind short_guard_seq sgs_checker u_chk (
  .clk        (clk),
  .rst_n      (rst_core_n),
  .run_en     (run_en),
  .retry_mode (retry_mode),
  .hit_any    (hit_any),
  .therm_q    (therm_q),
  .st         (st),
  .bridge_en  (bridge_en),
  .warn_drv   (warn_drv)
);

// File: tb/sim_short_guard_seq.sv
`timescale 1ns/1ps
module sim_short_guard_seq;
  localparam int NSW  = 3;
  localparam int QUAL = 4;
  localparam int HOLD = 10;
  localparam int AOFF = 12;

  logic           clk = 1'b0;
  logic           rst_n;
  logic           run_en;
  logic           retry_mode;
  logic [NSW-1:0] short_hit;
  logic           therm_hot;
  logic           bridge_en;
  logic           warn_drv;

  int    n_tests = 0;
  int    n_fail  = 0;
  string cur_req = "R1";
  bit    done_flag = 1'b0;

  always #4 clk = ~clk;

  short_guard_seq #(.NUM_SW(NSW), .QUAL_CYC(QUAL), .HOLD_CYC(HOLD),
                    .AUTO_OFF_CYC(AOFF)) u0 (
    .clk(clk), .rst_n(rst_n), .run_en(run_en), .retry_mode(retry_mode),
    .short_hit(short_hit), .therm_hot(therm_hot),
    .bridge_en(bridge_en), .warn_drv(warn_drv));

  // Behavioural reference: 0 run, 1 hold-off, 2 recheck, 3 locked, 4 pause
  int m_phase = 0, m_streak = 0, m_elapsed = 0, m_sync = 0;
  bit m_hot = 0;
  bit m_started = 0;

  always @(posedge clk) begin
    m_started <= 1'b1;
    if (!rst_n) begin
      m_sync = 0; m_phase = 0; m_streak = 0; m_elapsed = 0; m_hot = 0;
    end else if (m_sync < 2) begin
      m_sync = m_sync + 1; m_phase = 0; m_streak = 0; m_elapsed = 0; m_hot = 0;
    end else begin
      m_hot = therm_hot;
      if (!run_en) begin
        m_phase = 0; m_streak = 0; m_elapsed = 0;
      end else if (m_phase == 0 || m_phase == 2) begin
        if (short_hit != 0) begin
          m_streak = m_streak + 1;
          if (m_streak == QUAL) begin
            m_streak = 0; m_elapsed = 0;
            if (m_phase == 2) m_phase = 3;
            else m_phase = retry_mode ? 4 : 1;
          end
        end else begin
          m_streak = 0; m_phase = 0;
        end
      end else if (m_phase == 1 || m_phase == 4) begin
        m_elapsed = m_elapsed + 1;
        if (m_phase == 1 && m_elapsed == HOLD) begin m_phase = 2; m_elapsed = 0; end
        if (m_phase == 4 && m_elapsed == AOFF) begin m_phase = 0; m_elapsed = 0; end
      end
    end
  end

  always @(negedge clk) begin
    if (m_started && !done_flag) begin
      bit exp_b;
      exp_b = (m_phase == 0 || m_phase == 2) && !m_hot;
      n_tests++;
      if (bridge_en !== exp_b || warn_drv !== !exp_b) begin
        n_fail++;
        $display("FAIL %s model: bridge_en=%0b warn_drv=%0b expected %0b/%0b",
                 cur_req, bridge_en, warn_drv, exp_b, !exp_b);
      end
    end
  end

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic expect_lvl(input bit exp_b, input string req);
    n_tests++;
    if (bridge_en !== exp_b || warn_drv !== !exp_b) begin
      n_fail++;
      $display("FAIL %s: bridge_en=%0b warn_drv=%0b expected %0b/%0b",
               req, bridge_en, warn_drv, exp_b, !exp_b);
    end
  endtask

  initial begin
    int rises;
    bit prev_b;
    rst_n = 1'b0; run_en = 1'b1; retry_mode = 1'b0;
    short_hit = '0; therm_hot = 1'b0;
    wait_n(3);
    rst_n = 1'b1;
    wait_n(3);
    cur_req = "R1"; expect_lvl(1'b1, "R1");

    // R2: short pulses one cycle too short are filtered, restart on a gap
    cur_req = "R2";
    short_hit = 3'b001; wait_n(QUAL-1); short_hit = '0; wait_n(2);
    expect_lvl(1'b1, "R2");
    short_hit = 3'b100; wait_n(QUAL-1); short_hit = '0; wait_n(1);
    short_hit = 3'b010; wait_n(QUAL-1); short_hit = '0; wait_n(2);
    expect_lvl(1'b1, "R2");
    short_hit = 3'b010; wait_n(QUAL+2);
    expect_lvl(1'b0, "R2");

    // R3: hold-off then bridge returns; short gone at recheck
    cur_req = "R3";
    short_hit = '0; wait_n(HOLD+2);
    expect_lvl(1'b1, "R3");

    // R5: a later short restarts the full sequence
    cur_req = "R5";
    wait_n(3);
    short_hit = 3'b001; wait_n(QUAL+2); expect_lvl(1'b0, "R5");
    short_hit = '0; wait_n(HOLD+2); expect_lvl(1'b1, "R5");

    // R4: persistent short locks; later release of short has no effect
    cur_req = "R4";
    short_hit = 3'b110; wait_n(QUAL+HOLD+QUAL+8);
    expect_lvl(1'b0, "R4");
    short_hit = '0; wait_n(HOLD+QUAL+10);
    expect_lvl(1'b0, "R4");

    // R6: run_en low clears the lock and idles the sequencer
    cur_req = "R6";
    run_en = 1'b0; wait_n(1); run_en = 1'b1; wait_n(2);
    expect_lvl(1'b1, "R6");
    run_en = 1'b0; short_hit = 3'b111; wait_n(QUAL*3);
    expect_lvl(1'b1, "R6");
    short_hit = '0; wait_n(1); run_en = 1'b1; wait_n(2);

    // R7: auto-retry cycles off/on, never locks
    cur_req = "R7";
    retry_mode = 1'b1; short_hit = 3'b001;
    rises = 0; prev_b = bridge_en;
    for (int i = 0; i < 60; i++) begin
      @(negedge clk);
      if (bridge_en && !prev_b) rises++;
      prev_b = bridge_en;
    end
    n_tests++;
    if (rises < 2) begin
      n_fail++;
      $display("FAIL R7: bridge re-enable count=%0d expected >=2", rises);
    end
    short_hit = '0; wait_n(AOFF+3);
    expect_lvl(1'b1, "R7");

    // R10: mode captured at confirmation; pause length kept after pin change
    cur_req = "R10";
    retry_mode = 1'b1; short_hit = 3'b100;
    wait_n(QUAL+1);
    short_hit = '0; retry_mode = 1'b0;
    wait_n(HOLD);
    expect_lvl(1'b0, "R10");
    wait_n(2);
    expect_lvl(1'b1, "R10");

    // R8: thermal off and automatic restore; R9 warning follows
    cur_req = "R8";
    wait_n(3);
    therm_hot = 1'b1; wait_n(2);
    expect_lvl(1'b0, "R8");
    cur_req = "R9"; expect_lvl(1'b0, "R9");
    therm_hot = 1'b0; wait_n(2);
    cur_req = "R8"; expect_lvl(1'b1, "R8");
    wait_n(4);

    done_flag = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done_flag) begin
      done_flag = 1'b1;
      n_tests++; n_fail++;
      $display("FAIL watchdog: run did not complete, expected end before 20000 cycles");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule